// File: doc/BRIEF.md
# Line Write-Collect Buffer

The block sits between a write-through cache and the memory interconnect and collects single-word stores into whole-line writes. It holds a few line entries, each with a line tag, word storage and one dirty bit per word. Any entry can hold any line. A store to a line that already has an entry merges into that entry. A store to a new line takes a free entry. When no entry is free, one entry is picked at random by a free-running LFSR and written out. Only then is the store accepted.

Every line write carries a mask with one bit per word. Memory updates only the words this processor wrote, so words that other writers changed in the same line are kept. A drain request flushes every entry. The block signals completion only when every line write it has issued has been acknowledged by memory. This lets a release operation wait on it.

Top module: `wcollect_buf`

## Requirements
- R1: After reset there are no resident entries: `wr_ready` is 1, `mem_valid` is 0 and `drain_done` is 0.
- R2: Stores to a line that already has an entry merge into that single entry. A later drain emits exactly one line write for that line.
- R3: While a free entry exists, a store to a new line is accepted in the cycle it is presented and allocates an entry. No line write appears on the memory port.
- R4: With all entries occupied, a store to a line that has no entry is held (`wr_ready` 0). One resident line is written out, chosen at random among the residents. After that write is issued, the store is accepted.
- R5: In a line write, mask bit i (word i is bits [32i+31:32i] of `mem_data`) is 1 exactly when word i was stored since the entry was allocated. The word data is the most recent value stored to that word.
- R6: After a pulse on `drain_req`, every resident line is written out exactly once. While the drain is in progress, `wr_ready` stays 0.
- R7: `drain_done` is a one-cycle pulse. It is not raised while any issued line write is still unacknowledged. It is raised within a few cycles after the last acknowledgement, with all entries empty.
- R8: While a line write is pending on the memory port, no store is accepted, including a store to the line being written out. After the write issues, that store allocates a fresh entry holding only its own word.
- R9: `mem_valid` with `mem_tag`, `mem_mask` and `mem_data` holds steady until `mem_ready` accepts it. A line write issues in a cycle with both `mem_valid` and `mem_ready` high.
- R10: A drain requested with no resident entries and nothing outstanding produces no line write and raises `drain_done` within three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Store request |
| wr_ready | output | 1 | Store accepted this cycle when high with wr_valid |
| wr_waddr | input | WADDR_W (30) | Word address; upper bits form the line tag, lower 3 bits select the word |
| wr_data | input | WORD_W (32) | Store data |
| drain_req | input | 1 | Pulse to flush the whole buffer |
| drain_done | output | 1 | One-cycle pulse: buffer empty and every line write acknowledged |
| mem_valid | output | 1 | Line write pending |
| mem_ready | input | 1 | Memory accepts the pending line write |
| mem_tag | output | TAG_W (27) | Line tag of the write |
| mem_data | output | WORDS*WORD_W (256) | Line data, word i at bits [32i+31:32i] |
| mem_mask | output | WORDS (8) | Per-word write mask |
| mem_ack | input | 1 | One acknowledgement of an issued line write |

## Verification
A wrong dirty mask or a bad merge shows up only later, in the first line write for that line, as an extra or missing mask bit or a stale word. The bench keeps its own model of each line and compares every emitted line against it. A corrupted tag or valid bit shows up as a line write the model does not know, or as a line that is missing at the end of a drain. A miscounted acknowledgement shows up as `drain_done` rising too early, or within a few cycles after the last acknowledgement as no pulse at all.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  // index of the lowest set bit, zero when none is set
  function automatic int unsigned lowest_set(input logic [63:0] v);
    int unsigned r;
    r = 0;
    for (int i = 63; i >= 0; i--)
      if (v[i]) r = i;
    return r;
  endfunction
endpackage

// File: rtl/wcb_lfsr.sv
module wcb_lfsr
  import wcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [LFSR_W-1:0] state
);
  logic [LFSR_W-1:0] s_q;

  always_ff @(posedge clk) begin
    if (rst) s_q <= LFSR_W'(1);
    else if (s_q[0]) s_q <= (s_q >> 1) ^ LFSR_TAPS;
    else s_q <= s_q >> 1;
  end

  assign state = s_q;
endmodule

// File: rtl/wcb_lookup.sv
module wcb_lookup
  import wcb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 27,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            valid_vec,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]              req_tag,
  output logic [ENTRIES-1:0]            hit_vec,
  output logic                          hit,
  output logic [IDX_W-1:0]              hit_idx,
  output logic                          free_any,
  output logic [IDX_W-1:0]              free_idx,
  output logic                          any_valid,
  output logic [IDX_W-1:0]              first_valid
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_vec[g] && (tags[g] == req_tag);
  end

  assign hit         = |hit_vec;
  assign hit_idx     = IDX_W'(lowest_set(64'(hit_vec)));
  assign free_any    = ~&valid_vec;
  assign free_idx    = IDX_W'(lowest_set(64'(~valid_vec)));
  assign any_valid   = |valid_vec;
  assign first_valid = IDX_W'(lowest_set(64'(valid_vec)));
endmodule

// File: rtl/wcollect_buf.sv
module wcollect_buf
  import wcb_pkg::*;
#(
  parameter int WADDR_W    = 30,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int ENTRIES    = 4,
  parameter int OUTS_W     = 4,
  localparam int WORDS     = LINE_BYTES / (WORD_W / 8),
  localparam int WSEL_W    = $clog2(WORDS),
  localparam int TAG_W     = WADDR_W - WSEL_W,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [WADDR_W-1:0]      wr_waddr,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic                    drain_req,
  output logic                    drain_done,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [TAG_W-1:0]        mem_tag,
  output logic [WORDS*WORD_W-1:0] mem_data,
  output logic [WORDS-1:0]        mem_mask,
  input  logic                    mem_ack
);
  // entry storage
  logic [ENTRIES-1:0]                        valid_q;
  logic [ENTRIES-1:0][TAG_W-1:0]             tag_q;
  logic [ENTRIES-1:0][WORDS-1:0]             mask_q;
  logic [ENTRIES-1:0][WORDS-1:0][WORD_W-1:0] data_q;

  // eviction and drain state
  logic                    evict_q, drain_q, done_q;
  logic [IDX_W-1:0]        ev_idx_q;
  logic [OUTS_W-1:0]       outs_q;
  logic [TAG_W-1:0]        out_tag_q;
  logic [WORDS*WORD_W-1:0] out_data_q;
  logic [WORDS-1:0]        out_mask_q;

  logic [TAG_W-1:0]   req_tag;
  logic [WSEL_W-1:0]  wsel;
  logic [ENTRIES-1:0] hit_vec;
  logic               hit, free_any, any_valid;
  logic [IDX_W-1:0]   hit_idx, free_idx, first_valid, tgt_idx, victim;
  logic [LFSR_W-1:0]  rnd;
  logic               wr_fire, need_ev, issue, outs_full, drain_fin;

  assign req_tag = wr_waddr[WADDR_W-1:WSEL_W];
  assign wsel    = wr_waddr[WSEL_W-1:0];

  wcb_lookup #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_lookup (
    .valid_vec(valid_q), .tags(tag_q), .req_tag(req_tag),
    .hit_vec(hit_vec), .hit(hit), .hit_idx(hit_idx),
    .free_any(free_any), .free_idx(free_idx),
    .any_valid(any_valid), .first_valid(first_valid)
  );

  wcb_lfsr u_lfsr (.clk(clk), .rst(rst), .state(rnd));

  assign outs_full = &outs_q;
  assign wr_ready  = !evict_q && !drain_q && (hit || free_any);
  assign wr_fire   = wr_valid && wr_ready;
  assign tgt_idx   = hit ? hit_idx : free_idx;
  assign victim    = drain_q ? first_valid : IDX_W'(rnd % LFSR_W'(ENTRIES));
  assign need_ev   = !evict_q && !outs_full &&
                     (drain_q ? any_valid : (wr_valid && !hit && !free_any));
  assign issue     = evict_q && mem_ready;
  assign drain_fin = drain_q && !any_valid && !evict_q && (outs_q == '0);

  // entry array: one word written per store, whole line read for eviction
  always_ff @(posedge clk) begin
    if (wr_fire) data_q[tgt_idx][wsel] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      tag_q   <= '0;
      mask_q  <= '0;
    end else begin
      if (wr_fire) begin
        valid_q[tgt_idx] <= 1'b1;
        if (hit) begin
          mask_q[tgt_idx][wsel] <= 1'b1;
        end else begin
          tag_q[tgt_idx]  <= req_tag;
          mask_q[tgt_idx] <= WORDS'(1) << wsel;
        end
      end
      if (issue) valid_q[ev_idx_q] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evict_q    <= 1'b0;
      ev_idx_q   <= '0;
      out_tag_q  <= '0;
      out_data_q <= '0;
      out_mask_q <= '0;
    end else if (need_ev) begin
      evict_q    <= 1'b1;
      ev_idx_q   <= victim;
      out_tag_q  <= tag_q[victim];
      out_data_q <= data_q[victim];
      out_mask_q <= mask_q[victim];
    end else if (issue) begin
      evict_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outs_q  <= '0;
      drain_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      outs_q <= outs_q + OUTS_W'(issue) - OUTS_W'(mem_ack);
      done_q <= drain_fin;
      if (drain_fin) drain_q <= 1'b0;
      else if (drain_req) drain_q <= 1'b1;
    end
  end

  assign mem_valid  = evict_q;
  assign mem_tag    = out_tag_q;
  assign mem_data   = out_data_q;
  assign mem_mask   = out_mask_q;
  assign drain_done = done_q;

  // R2: a line never sits in two entries
  p_single_hit_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  // R3: an accepted store leaves at least one entry resident
  p_alloc_r3: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (valid_q != '0));
  // R8: no store is taken while a line write is pending
  p_stall_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |-> !mem_valid);
  // R9: a pending line write holds still until taken
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_tag) && $stable(mem_mask)));
  // R7: completion only with nothing resident and nothing unacknowledged
  p_done_clean_r7: assert property (@(posedge clk) disable iff (rst)
    drain_done |-> ((outs_q == '0) && (valid_q == '0)));
  // R7: acknowledgements never exceed issued writes
  p_ack_bound_r7: assert property (@(posedge clk) disable iff (rst)
    mem_ack |-> (outs_q != '0));
endmodule

// File: tb/wcollect_buf_tb.sv
module wcollect_buf_tb;
  localparam int TAG_W = 27;
  logic clk = 0, rst = 1;
  logic wr_valid = 0, drain_req = 0, mem_ready = 0, mem_ack = 0;
  logic [29:0] wr_waddr = '0;
  logic [31:0] wr_data = '0;
  logic wr_ready, drain_done, mem_valid;
  logic [TAG_W-1:0] mem_tag;
  logic [255:0] mem_data;
  logic [7:0] mem_mask;

  int checks = 0, failures = 0, pend = 0;
  logic [7:0]   mm [logic [TAG_W-1:0]];
  logic [255:0] md [logic [TAG_W-1:0]];

  wcollect_buf u_dut (.clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_waddr(wr_waddr), .wr_data(wr_data), .drain_req(drain_req), .drain_done(drain_done),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_tag(mem_tag), .mem_data(mem_data),
    .mem_mask(mem_mask), .mem_ack(mem_ack));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_wr(input logic [TAG_W-1:0] t, input int w, input logic [31:0] d);
    if (!mm.exists(t)) begin mm[t] = '0; md[t] = '0; end
    mm[t][w] = 1'b1;
    md[t][w*32 +: 32] = d;
  endtask

  task automatic wr(input logic [TAG_W-1:0] t, input int w, input logic [31:0] d, input string req);
    int n = 0;
    @(negedge clk);
    wr_valid = 1; wr_waddr = {t, 3'(w)}; wr_data = d;
    #1;
    chk(wr_ready, req, wr_ready, 1);
    while (!wr_ready && n < 30) begin @(negedge clk); #1; n++; end
    @(posedge clk); #1;
    wr_valid = 0;
    model_wr(t, w, d);
  endtask

  task automatic take_line(output logic [TAG_W-1:0] t, output logic [7:0] m, output logic [255:0] d);
    int n = 0;
    @(negedge clk);
    while (!mem_valid && n < 50) begin @(negedge clk); n++; end
    chk(mem_valid, "R9 line write present", mem_valid, 1);
    t = mem_tag; m = mem_mask; d = mem_data;
    mem_ready = 1;
    @(negedge clk);
    mem_ready = 0;
    pend++;
  endtask

  task automatic check_line(input logic [TAG_W-1:0] t, input logic [7:0] m, input logic [255:0] d);
    logic [255:0] sel;
    chk(mm.exists(t), "R2 emitted line is resident", 64'(t), 0);
    if (mm.exists(t)) begin
      chk(m == mm[t], "R5 mask", m, mm[t]);
      sel = '0;
      for (int i = 0; i < 8; i++) if (mm[t][i]) sel[i*32 +: 32] = '1;
      chk((d & sel) == (md[t] & sel), "R5 data", 64'(d & sel), 64'(md[t] & sel));
      mm.delete(t); md.delete(t);
    end
  endtask

  task automatic ack_all();
    while (pend > 0) begin
      @(negedge clk); mem_ack = 1;
      @(negedge clk); mem_ack = 0;
      pend--;
    end
  endtask

  task automatic drain_all(input int exp_n, input bit probe);
    logic [TAG_W-1:0] t; logic [7:0] m; logic [255:0] d;
    bit seen = 0; int pulses = 0;
    @(negedge clk); drain_req = 1;
    @(negedge clk); drain_req = 0;
    for (int i = 0; i < exp_n; i++) begin
      if (probe && i == 0) begin
        while (!mem_valid) @(negedge clk);
        wr_valid = 1; wr_waddr = {mem_tag, 3'd1}; wr_data = 32'hDEAD;
        #1;
        chk(!wr_ready, "R6 store held during drain", wr_ready, 0);
        wr_valid = 0;
      end
      take_line(t, m, d);
      check_line(t, m, d);
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!mem_valid, "R6 no extra line write", mem_valid, 0);
      if (exp_n > 0) chk(!drain_done, "R7 done held while unacked", drain_done, 0);
      else if (drain_done) pulses++;
    end
    ack_all();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (drain_done) begin seen = 1; pulses++; end
    end
    if (exp_n > 0) chk(seen && pulses == 1, "R7 single done pulse", 64'(pulses), 1);
    chk(mm.size() == 0, "R6 every line drained", 64'(mm.size()), 0);
  endtask

  task automatic t_reset();
    #1;
    chk(wr_ready == 1, "R1 wr_ready", wr_ready, 1);
    chk(mem_valid == 0, "R1 mem_valid", mem_valid, 0);
    chk(drain_done == 0, "R1 drain_done", drain_done, 0);
  endtask

  task automatic t_merge();
    wr(27'h100, 0, 32'h1111_0000, "R3 alloc");
    wr(27'h100, 3, 32'h3333_0000, "R2 merge");
    wr(27'h100, 3, 32'h3333_0001, "R5 overwrite");
    wr(27'h100, 7, 32'h7777_0000, "R2 merge");
    @(negedge clk);
    chk(!mem_valid, "R3 no write before drain", mem_valid, 0);
    drain_all(1, 0);
  endtask

  task automatic t_evict();
    logic [TAG_W-1:0] t, vt; logic [7:0] m; logic [255:0] d;
    bit ok;
    for (int i = 0; i < 4; i++) wr(27'h200 + 27'(i), i, 32'hA000 + 32'(i), "R3 alloc with space");
    wr(27'h201, 5, 32'hB005, "R2 merge when full");
    @(negedge clk);
    chk(!mem_valid, "R3 no write while space", mem_valid, 0);
    wr_valid = 1; wr_waddr = {27'h2FF, 3'd2}; wr_data = 32'hC002;
    #1;
    chk(!wr_ready, "R4 full miss held", wr_ready, 0);
    while (!mem_valid) @(negedge clk);
    vt = mem_tag; m = mem_mask; d = mem_data;
    ok = (vt >= 27'h200 && vt <= 27'h203);
    chk(ok, "R4 victim is resident", 64'(vt), 27'h200);
    wr_waddr = {vt, 3'd6}; wr_data = 32'hE006;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(!wr_ready, "R8 store held while write pending", wr_ready, 0);
      chk(mem_valid && mem_tag == vt && mem_mask == m, "R9 hold", 64'(mem_tag), 64'(vt));
    end
    take_line(t, m, d);
    check_line(t, m, d);
    #1;
    chk(wr_ready, "R8 store taken after issue", wr_ready, 1);
    @(posedge clk); #1;
    wr_valid = 0;
    model_wr(vt, 6, 32'hE006);
    drain_all(4, 1);
  endtask

  task automatic t_empty_drain();
    bit seen = 0;
    @(negedge clk); drain_req = 1;
    @(negedge clk); drain_req = 0;
    for (int i = 0; i < 3; i++) begin
      if (drain_done) seen = 1;
      chk(!mem_valid, "R10 no line write", mem_valid, 0);
      @(negedge clk);
    end
    chk(seen, "R10 done on empty", seen, 1);
    t_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_merge();
    t_evict();
    t_empty_drain();
    t_merge();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule